// File: doc/BRIEF.md
# Context-decision pair sequencer

The sequencer sits between a column-parallel context former and a single-input arithmetic coder. In one cycle the context former codes one four-sample column of a stripe. That produces a burst of context/decision pairs, typically four to ten of them, placed in a row of slots. Each slot carries a valid flag, a 5-bit context and a decision bit. Slots that did not produce a pair are flagged invalid.

The sequencer packs the valid slots of each burst into a circular buffer and hands them to the coder one per cycle through a valid/ready handshake. Order is set by slot index within a burst and by arrival order across bursts. The context former must therefore place a sample's zero-coding pair in a lower slot than that sample's sign-coding pair. The sequencer then keeps that order. When the buffer cannot take a full burst, it deasserts its ready output and ignores the slots presented in that cycle. `DEPTH` must be a power of two and at least `SLOTS`.

Top module: `cxd_sequencer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Valid pairs leave in ascending slot index within a burst, and every pair of an earlier accepted burst leaves before any pair of a later one. A zero-coding pair placed in a lower slot than a sign-coding pair therefore always precedes it.
- R3: Invalid slots are skipped. While the buffer holds a pair, `out_valid` is 1, so a gap in the slots never produces an idle output cycle.
- R4: Slots presented in a cycle where `in_ready` is 0 are ignored and never appear at the output.
- R5: `in_ready` is 1 exactly when the number of free buffer entries (`DEPTH` minus the pairs held) is at least `SLOTS`.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid` at 1 with `out_cx` and `out_d` unchanged.
- R7: Slot i takes its context from `in_cx[i*5 +: 5]`, its decision from `in_d[i]` and its valid flag from `in_vld[i]`. The output shows the context on `out_cx` and the decision on `out_d`.
- R8: A pair accepted at a clock edge into an empty buffer is presented on the output in the following cycle.
- R9: A burst with all slots invalid adds nothing to the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | SLOTS | Per-slot valid flags |
| in_cx | input | SLOTS*CXW | Per-slot contexts, slot i at bits i*CXW upward |
| in_d | input | SLOTS | Per-slot decision bits |
| in_ready | output | 1 | Burst can be accepted this cycle |
| out_valid | output | 1 | A pair is presented |
| out_ready | input | 1 | Coder takes the presented pair |
| out_cx | output | CXW | Presented context |
| out_d | output | 1 | Presented decision |

## Verification
The bench builds the block with ten slots, 5-bit contexts and a 16-entry buffer. With those values the space left for a second burst is only six entries, so the backpressure threshold is crossed every few cycles whenever the coder stalls. Pointer wrap-around is also reached many times during the run. A queue model predicts ready, valid and the presented pair for every cycle under sparse, full, empty and scattered slot patterns, with the coder both always ready and randomly stalling.

// File: rtl/cxd_sequencer.sv
module cxd_sequencer #(
  parameter int SLOTS = 10,
  parameter int CXW   = 5,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SLOTS-1:0]     in_vld,
  input  logic [SLOTS*CXW-1:0] in_cx,
  input  logic [SLOTS-1:0]     in_d,
  output logic                 in_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [CXW-1:0]       out_cx,
  output logic                 out_d
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = CXW + 1;

  logic [PW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [AW-1:0] slot_pos [SLOTS];
  logic [CW-1:0] n_new;
  logic          pop;

  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < SLOTS; i++) begin
      slot_pos[i] = wr_ptr + acc[AW-1:0];
      if (in_vld[i]) acc = acc + CW'(1);
    end
    n_new = in_ready ? acc : '0;
  end

  assign in_ready  = count <= CW'(DEPTH - SLOTS);
  assign out_valid = count != '0;
  assign pop       = out_valid && out_ready;
  assign {out_cx, out_d} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (in_ready)
      for (int i = 0; i < SLOTS; i++)
        if (in_vld[i]) mem[slot_pos[i]] <= {in_cx[i*CXW +: CXW], in_d[i]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + n_new[AW-1:0];
      rd_ptr <= rd_ptr + AW'(pop);
      count  <= count + n_new - CW'(pop);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cx) && $stable(out_d));

  assert_refused_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> count <= $past(count));

  assert_empty_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld == '0 && !pop |=> $stable(count));

  assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
endmodule

// File: tb/cxd_sequencer_tb.sv
module cxd_sequencer_tb;
  localparam int SLOTS = 10;
  localparam int CXW   = 5;
  localparam int DEPTH = 16;

  logic                 clk = 0;
  logic                 rst_n = 0;
  logic [SLOTS-1:0]     in_vld = '0;
  logic [SLOTS*CXW-1:0] in_cx = '0;
  logic [SLOTS-1:0]     in_d = '0;
  logic                 in_ready, out_valid, out_cx_unused;
  logic                 out_ready = 0;
  logic [CXW-1:0]       out_cx;
  logic                 out_d;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [CXW:0] model_q [$];

  always #4 clk = ~clk;

  cxd_sequencer #(.SLOTS(SLOTS), .CXW(CXW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cx(in_cx), .in_d(in_d),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_cx(out_cx), .out_d(out_d));

  assign out_cx_unused = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic       stalled_prev = 0;
  logic [CXW:0] stalled_word;

  task automatic step(input logic [SLOTS-1:0] vld, input bit rdy);
    bit exp_ready, exp_valid;
    exp_ready = (DEPTH - model_q.size()) >= SLOTS;
    exp_valid = model_q.size() != 0;
    chk(in_ready == exp_ready, "R5 in_ready", in_ready, exp_ready);
    chk(out_valid == exp_valid, "R3 out_valid", out_valid, exp_valid);
    if (exp_valid && out_valid)
      chk({out_cx, out_d} == model_q[0], "R2/R7 pair order", {out_cx, out_d}, model_q[0]);
    if (stalled_prev)
      chk({out_cx, out_d} == stalled_word, "R6 held while stalled", {out_cx, out_d}, stalled_word);
    in_vld = vld;
    for (int i = 0; i < SLOTS; i++) begin
      in_cx[i*CXW +: CXW] = CXW'($urandom);
      in_d[i] = 1'($urandom);
    end
    out_ready = rdy;
    stalled_prev = exp_valid && !rdy;
    if (exp_valid) stalled_word = model_q[0];
    if (exp_valid && rdy) void'(model_q.pop_front());
    if (exp_ready)
      for (int i = 0; i < SLOTS; i++)
        if (vld[i]) model_q.push_back({in_cx[i*CXW +: CXW], in_d[i]});
    @(negedge clk);
  endtask

  function automatic logic [SLOTS-1:0] burst(input int n);
    logic [SLOTS-1:0] v = '0;
    int placed = 0;
    while (placed < n) begin
      int k = $urandom_range(SLOTS - 1);
      if (!v[k]) begin v[k] = 1'b1; placed++; end
    end
    return v;
  endfunction

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R8: single pair into an empty buffer is shown the next cycle
    step(10'b0000100000, 1'b0);
    chk(out_valid == 1'b1, "R8 next-cycle presence", out_valid, 1);
    step('0, 1'b1);
    // R9: all-invalid bursts add nothing
    for (int i = 0; i < 4; i++) step('0, 1'b1);
    chk(out_valid == 1'b0, "R9 empty bursts", out_valid, 0);
    // R2/R3: coder always ready, four to ten valid slots, scattered
    for (int i = 0; i < 400; i++) step(burst($urandom_range(4, SLOTS)), 1'b1);
    // R4/R5/R6: coder stalls randomly, full bursts force backpressure
    for (int i = 0; i < 1500; i++)
      step(($urandom_range(3) == 0) ? '0 : burst($urandom_range(1, SLOTS)),
           $urandom_range(2) == 0);
    // R4: hold coder off until full, then offer bursts that must be ignored
    for (int i = 0; i < 6; i++) step({SLOTS{1'b1}}, 1'b0);
    chk(in_ready == 1'b0, "R4 backpressure reached", in_ready, 0);
    for (int i = 0; i < 5; i++) step({SLOTS{1'b1}}, 1'b0);
    // drain and confirm only accepted pairs came out
    for (int i = 0; i < 40; i++) step('0, 1'b1);
    chk(out_valid == 1'b0, "R4 drained without refused pairs", out_valid, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule